// File: doc/BRIEF.md
# ATM Cell Transmit Port with Dual-Clock Cell Buffer

This block is the cell entry point of a physical-layer transmit path. An ATM-layer device pushes cells into it over a UTOPIA Level 2 style transmit bus, and the block acts as one PHY port. That bus runs on its own write clock. The block checks parity on every word and puts whole cells into a small cell buffer. The line-side cell processor then takes them out one byte at a time on an unrelated line clock. Framing, HEC and scrambling happen further down the path.

Flow control works in whole cells. A cell-available output tells the ATM-layer device that a complete cell slot is free. The two clock domains exchange only cell-granular Gray-coded pointers. Each pointer passes through a two-stage synchronizer, so the occupancy that either side sees is always safe. The bus width is a build parameter, either 8 or 16 bits. The line side always receives 53-byte cells.

Top module: `atm_cell_tx_if`

## Requirements
- R1: With DATA_W=8 a cell is 53 words. The word presented with `atm_soc` high is byte 1. Bytes leave the line side in the order they were written.
- R2: With DATA_W=16 a cell is 27 words. Each word carries its bits 15:8 first and bits 7:0 second. In word 3 of the cell, bits 15:8 become byte 5 and bits 7:0 (the pad) are discarded, so the line side still gets 53 bytes.
- R3: `line_cell_rdy` is high while at least one complete cell is stored. While ready, each cycle with `line_rd` high moves the output to the next byte. `line_soc` is high only on byte 1. `line_rd` has no effect while `line_cell_rdy` is low.
- R4: Parity is odd: the XOR of the data word and `atm_par` must be 1. A mismatch sets `atm_par_err`, which stays set until reset. The word is still stored.
- R5: A start-of-cell word that arrives before the current cell's last word drops the partial cell and sets `atm_runt_err`, which stays set until reset. The new cell is accepted in the same slot.
- R6: Words that arrive with `atm_soc` low while no cell is in progress are ignored.
- R7: The buffer holds 4 cells. `atm_cell_avail` is high after reset. It goes low in the cycle after the first word of the cell that takes the last free slot is accepted. It stays low while all 4 slots are stored or being written.
- R8: A cell whose first word arrives while no slot is free is dropped whole. Stored cells are unaffected.
- R9: The read and write cell pointers cross domains Gray-coded and change by at most one bit per clock. After a cell has been fully read, `atm_cell_avail` returns high within 10 write clocks.
- R10: Cells leave in arrival order. `line_cell_rdy` is low when no complete cell is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| atm_clk | input | 1 | ATM-layer write clock |
| atm_rst_n | input | 1 | Synchronous active-low reset, write domain |
| atm_wr_en | input | 1 | Word valid on the transmit bus |
| atm_soc | input | 1 | Marks the first word of a cell |
| atm_data | input | DATA_W | Transmit data word |
| atm_par | input | 1 | Odd parity bit for `atm_data` |
| atm_cell_avail | output | 1 | A full cell slot is free |
| atm_par_err | output | 1 | Sticky parity mismatch flag |
| atm_runt_err | output | 1 | Sticky truncated-cell flag |
| line_clk | input | 1 | Line-side read clock |
| line_rst_n | input | 1 | Synchronous active-low reset, line domain |
| line_rd | input | 1 | Byte read strobe |
| line_cell_rdy | output | 1 | A complete cell is stored |
| line_data | output | 8 | Current byte of the head cell |
| line_soc | output | 1 | Current byte is byte 1 of a cell |

## Verification
The bench builds two copies side by side, one with an 8-bit bus and one with a 16-bit bus, both with the default depth of 4 cells. The 16-bit copy exercises the pad-byte removal and a different last-word index. The small depth means a few cells fill the buffer, so the full boundary, the dropped overflow cell and the recovery of cell-available after draining all come up quickly. The two clocks have unrelated periods, which makes the synchronizer lag real. The reference model therefore enforces only the safe direction of each flag on every clock and checks the settled values after quiet periods.

// File: rtl/atm_txif_pkg.sv
// Package: shared constants and pointer helpers for the cell transmit port.
// Assumes pointers are at most 8 bits wide.
package atm_txif_pkg;
    localparam int CELL_BYTES = 53;

    // Number of bus words that carry one cell for a given bus width
    function automatic int words_per_cell(input int dw);
        return (dw == 16) ? 27 : 53;
    endfunction

    // Gray to binary conversion, 8-bit container
    function automatic logic [7:0] gray_to_bin(input logic [7:0] g);
        logic [7:0] b;
        b[7] = g[7];
        for (int i = 6; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction
endpackage

// File: rtl/ptr_sync.sv
// Module: two-stage synchronizer for a Gray-coded pointer.
// Assumes the input changes by at most one bit per source clock.
module ptr_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    // Two flops in the destination domain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/cell_ram.sv
// Module: byte-wide cell storage, two write lanes in the write domain,
// asynchronous read for the line side. Assumes the two lanes never
// write the same address in one cycle.
module cell_ram #(
    parameter int CELLS  = 4,
    parameter int ADDR_W = 8
) (
    input  logic              wclk,
    input  logic              we0,
    input  logic [ADDR_W-1:0] waddr0,
    input  logic [7:0]        wdata0,
    input  logic              we1,
    input  logic [ADDR_W-1:0] waddr1,
    input  logic [7:0]        wdata1,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);
    import atm_txif_pkg::*;
    localparam int BYTES = CELLS * CELL_BYTES;

    logic [7:0] mem [BYTES];

    // Store up to two bytes per write clock
    always_ff @(posedge wclk) begin
        if (we0) mem[int'(waddr0)] <= wdata0;
        if (we1) mem[int'(waddr1)] <= wdata1;
    end

    assign rdata = mem[int'(raddr)];
endmodule

// File: rtl/atm_tx_wr.sv
// Module: write side. Checks parity, frames cells on start-of-cell,
// discards runts, maps words to bytes and drives cell-available.
// Assumes CELLS is a power of two and DATA_W is 8 or 16.
module atm_tx_wr #(
    parameter int DATA_W = 8,
    parameter int CELLS  = 4,
    parameter int PTR_W  = 3,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              soc,
    input  logic [DATA_W-1:0] data,
    input  logic              par,
    input  logic [PTR_W-1:0]  rd_gray_s,
    output logic [PTR_W-1:0]  wr_gray,
    output logic [PTR_W-1:0]  used,
    output logic              in_cell,
    output logic              cell_avail,
    output logic              par_err,
    output logic              runt_err,
    output logic              we0,
    output logic [ADDR_W-1:0] waddr0,
    output logic [7:0]        wdata0,
    output logic              we1,
    output logic [ADDR_W-1:0] waddr1,
    output logic [7:0]        wdata1
);
    import atm_txif_pkg::*;
    localparam int WPC   = words_per_cell(DATA_W);
    localparam int IDX_W = $clog2(WPC);

    logic [PTR_W-1:0] wr_bin, rd_bin, wr_bin_nx;
    logic [IDX_W-1:0] word_idx;
    logic [7:0]       rd_bin8;
    logic [PTR_W:0]   busy;
    logic             has_room, take_first, take_next, take, last_word;
    int               cur_i, base;

    // Occupancy as seen from the write domain
    always_comb begin
        rd_bin8    = gray_to_bin(8'(rd_gray_s));
        rd_bin     = rd_bin8[PTR_W-1:0];
        used       = wr_bin - rd_bin;
        busy       = {1'b0, used} + {{PTR_W{1'b0}}, in_cell};
        has_room   = used < PTR_W'(CELLS);
        cell_avail = busy < (PTR_W+1)'(CELLS);
    end

    // Word acceptance and position inside the cell
    always_comb begin
        take_first = wr_en && soc && (in_cell || has_room);
        take_next  = wr_en && !soc && in_cell;
        take       = take_first || take_next;
        cur_i      = soc ? 0 : int'(word_idx);
        last_word  = take_next && (cur_i == WPC - 1);
        base       = int'(wr_bin[PTR_W-2:0]) * CELL_BYTES;
        wr_bin_nx  = wr_bin + 1'b1;
    end

    // Cell framing, pointer advance and sticky flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_bin   <= '0;
            wr_gray  <= '0;
            in_cell  <= 1'b0;
            word_idx <= '0;
            par_err  <= 1'b0;
            runt_err <= 1'b0;
        end else begin
            if (wr_en && !(^{data, par})) par_err <= 1'b1;
            if (take_first) begin
                if (in_cell) runt_err <= 1'b1;
                in_cell  <= 1'b1;
                word_idx <= IDX_W'(1);
            end else if (last_word) begin
                in_cell  <= 1'b0;
                word_idx <= '0;
                wr_bin   <= wr_bin_nx;
                wr_gray  <= wr_bin_nx ^ (wr_bin_nx >> 1);
            end else if (take_next) begin
                word_idx <= word_idx + 1'b1;
            end
        end
    end

    // Word-to-byte placement chosen by bus width
    generate
        if (DATA_W == 16) begin : g_w16
            always_comb begin
                we0    = take;
                we1    = take && (cur_i != 2);
                waddr0 = ADDR_W'(base + ((cur_i <= 2) ? 2 * cur_i : 2 * cur_i - 1));
                waddr1 = ADDR_W'(base + ((cur_i < 2) ? 2 * cur_i + 1 : 2 * cur_i));
                wdata0 = data[15:8];
                wdata1 = data[7:0];
            end
        end else begin : g_w8
            always_comb begin
                we0    = take;
                we1    = 1'b0;
                waddr0 = ADDR_W'(base + cur_i);
                waddr1 = '0;
                wdata0 = data[7:0];
                wdata1 = '0;
            end
        end
    endgenerate
endmodule

// File: rtl/atm_tx_rd.sv
// Module: line-side reader. Presents the head cell one byte at a time
// and frees the slot after the last byte. Assumes CELLS is a power of two.
module atm_tx_rd #(
    parameter int CELLS  = 4,
    parameter int PTR_W  = 3,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  logic [PTR_W-1:0]  wr_gray_s,
    output logic [PTR_W-1:0]  rd_gray,
    output logic              cell_rdy,
    output logic              soc,
    output logic [ADDR_W-1:0] raddr
);
    import atm_txif_pkg::*;

    logic [PTR_W-1:0] rd_bin, wr_bin, rd_bin_nx;
    logic [7:0]       wr_bin8;
    logic [5:0]       byte_idx;

    // Readiness and current byte address
    always_comb begin
        wr_bin8   = gray_to_bin(8'(wr_gray_s));
        wr_bin    = wr_bin8[PTR_W-1:0];
        cell_rdy  = wr_bin != rd_bin;
        soc       = cell_rdy && (byte_idx == '0);
        raddr     = ADDR_W'(int'(rd_bin[PTR_W-2:0]) * CELL_BYTES + int'(byte_idx));
        rd_bin_nx = rd_bin + 1'b1;
    end

    // Byte advance and slot release
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_bin   <= '0;
            rd_gray  <= '0;
            byte_idx <= '0;
        end else if (rd && cell_rdy) begin
            if (int'(byte_idx) == CELL_BYTES - 1) begin
                byte_idx <= '0;
                rd_bin   <= rd_bin_nx;
                rd_gray  <= rd_bin_nx ^ (rd_bin_nx >> 1);
            end else begin
                byte_idx <= byte_idx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/atm_cell_tx_if.sv
// Module: top of the cell transmit port. Joins the write side, the cell
// storage, the pointer synchronizers and the line-side reader.
// Assumes CELLS is a power of two no larger than 64.
module atm_cell_tx_if #(
    parameter int DATA_W = 8,
    parameter int CELLS  = 4
) (
    input  logic              atm_clk,
    input  logic              atm_rst_n,
    input  logic              atm_wr_en,
    input  logic              atm_soc,
    input  logic [DATA_W-1:0] atm_data,
    input  logic              atm_par,
    output logic              atm_cell_avail,
    output logic              atm_par_err,
    output logic              atm_runt_err,
    input  logic              line_clk,
    input  logic              line_rst_n,
    input  logic              line_rd,
    output logic              line_cell_rdy,
    output logic [7:0]        line_data,
    output logic              line_soc
);
    import atm_txif_pkg::*;
    localparam int PTR_W  = $clog2(CELLS) + 1;
    localparam int ADDR_W = $clog2(CELLS * CELL_BYTES);

    logic [PTR_W-1:0]  wr_gray, rd_gray, wr_gray_s, rd_gray_s, wr_used;
    logic              wr_in_cell, we0, we1;
    logic [ADDR_W-1:0] waddr0, waddr1, raddr;
    logic [7:0]        wdata0, wdata1;

    atm_tx_wr #(.DATA_W(DATA_W), .CELLS(CELLS), .PTR_W(PTR_W), .ADDR_W(ADDR_W)) u_wr (
        .clk(atm_clk), .rst_n(atm_rst_n), .wr_en(atm_wr_en), .soc(atm_soc),
        .data(atm_data), .par(atm_par), .rd_gray_s(rd_gray_s),
        .wr_gray(wr_gray), .used(wr_used), .in_cell(wr_in_cell),
        .cell_avail(atm_cell_avail), .par_err(atm_par_err), .runt_err(atm_runt_err),
        .we0(we0), .waddr0(waddr0), .wdata0(wdata0),
        .we1(we1), .waddr1(waddr1), .wdata1(wdata1)
    );

    cell_ram #(.CELLS(CELLS), .ADDR_W(ADDR_W)) u_ram (
        .wclk(atm_clk), .we0(we0), .waddr0(waddr0), .wdata0(wdata0),
        .we1(we1), .waddr1(waddr1), .wdata1(wdata1),
        .raddr(raddr), .rdata(line_data)
    );

    ptr_sync #(.W(PTR_W)) u_sync_w2l (
        .clk(line_clk), .rst_n(line_rst_n), .d(wr_gray), .q(wr_gray_s)
    );

    ptr_sync #(.W(PTR_W)) u_sync_l2w (
        .clk(atm_clk), .rst_n(atm_rst_n), .d(rd_gray), .q(rd_gray_s)
    );

    atm_tx_rd #(.CELLS(CELLS), .PTR_W(PTR_W), .ADDR_W(ADDR_W)) u_rd (
        .clk(line_clk), .rst_n(line_rst_n), .rd(line_rd), .wr_gray_s(wr_gray_s),
        .rd_gray(rd_gray), .cell_rdy(line_cell_rdy), .soc(line_soc), .raddr(raddr)
    );
endmodule

// File: rtl/atm_txif_chk.sv
// Module: assertion checker bound to the cell transmit port.
// Assumes both resets are held low from time zero.
module atm_txif_chk #(
    parameter int PTR_W = 3,
    parameter int CELLS = 4
) (
    input logic             atm_clk,
    input logic             atm_rst_n,
    input logic             line_clk,
    input logic             line_rst_n,
    input logic [PTR_W-1:0] wr_gray,
    input logic [PTR_W-1:0] rd_gray,
    input logic [PTR_W-1:0] wr_used,
    input logic             wr_in_cell,
    input logic             atm_cell_avail,
    input logic             atm_par_err,
    input logic             atm_runt_err,
    input logic             line_soc,
    input logic             line_cell_rdy
);
    assert_wr_gray_step_R9: assert property (@(posedge atm_clk) disable iff (!atm_rst_n)
        $countones(wr_gray ^ $past(wr_gray)) <= 1);

    assert_rd_gray_step_R9: assert property (@(posedge line_clk) disable iff (!line_rst_n)
        $countones(rd_gray ^ $past(rd_gray)) <= 1);

    assert_no_overflow_R7: assert property (@(posedge atm_clk) disable iff (!atm_rst_n)
        wr_used <= PTR_W'(CELLS));

    assert_full_no_avail_R7: assert property (@(posedge atm_clk) disable iff (!atm_rst_n)
        (wr_used == PTR_W'(CELLS)) |-> !atm_cell_avail);

    assert_writing_last_slot_R7: assert property (@(posedge atm_clk) disable iff (!atm_rst_n)
        (wr_in_cell && wr_used == PTR_W'(CELLS - 1)) |-> !atm_cell_avail);

    assert_par_sticky_R4: assert property (@(posedge atm_clk) disable iff (!atm_rst_n)
        atm_par_err |=> atm_par_err);

    assert_runt_sticky_R5: assert property (@(posedge atm_clk) disable iff (!atm_rst_n)
        atm_runt_err |=> atm_runt_err);

    assert_soc_needs_rdy_R3: assert property (@(posedge line_clk) disable iff (!line_rst_n)
        line_soc |-> line_cell_rdy);
endmodule

bind atm_cell_tx_if atm_txif_chk #(.PTR_W(PTR_W), .CELLS(CELLS)) u_chk (
    .atm_clk(atm_clk), .atm_rst_n(atm_rst_n), .line_clk(line_clk), .line_rst_n(line_rst_n),
    .wr_gray(wr_gray), .rd_gray(rd_gray), .wr_used(wr_used), .wr_in_cell(wr_in_cell),
    .atm_cell_avail(atm_cell_avail), .atm_par_err(atm_par_err), .atm_runt_err(atm_runt_err),
    .line_soc(line_soc), .line_cell_rdy(line_cell_rdy)
);

// File: tb/sim_atm_cell_tx_if.sv
// Bench: an 8-bit copy (u0) and a 16-bit copy (u1) against a behavioural
// queue model. Flags are checked every clock in their safe direction.
module sim_atm_cell_tx_if;
    logic atm_clk = 1'b0, line_clk = 1'b0;
    logic atm_rst_n = 1'b0, line_rst_n = 1'b0;
    always #2 atm_clk = ~atm_clk;
    always #3.5 line_clk = ~line_clk;

    logic        en [2], soc [2], par [2], rd [2];
    logic [7:0]  d8;
    logic [15:0] d16;
    logic        avail [2], perr [2], rerr [2], rdy [2], lsoc [2];
    logic [7:0]  ldat [2];

    atm_cell_tx_if #(.DATA_W(8), .CELLS(4)) u0 (
        .atm_clk(atm_clk), .atm_rst_n(atm_rst_n), .atm_wr_en(en[0]), .atm_soc(soc[0]),
        .atm_data(d8), .atm_par(par[0]), .atm_cell_avail(avail[0]),
        .atm_par_err(perr[0]), .atm_runt_err(rerr[0]),
        .line_clk(line_clk), .line_rst_n(line_rst_n), .line_rd(rd[0]),
        .line_cell_rdy(rdy[0]), .line_data(ldat[0]), .line_soc(lsoc[0]));

    atm_cell_tx_if #(.DATA_W(16), .CELLS(4)) u1 (
        .atm_clk(atm_clk), .atm_rst_n(atm_rst_n), .atm_wr_en(en[1]), .atm_soc(soc[1]),
        .atm_data(d16), .atm_par(par[1]), .atm_cell_avail(avail[1]),
        .atm_par_err(perr[1]), .atm_runt_err(rerr[1]),
        .line_clk(line_clk), .line_rst_n(line_rst_n), .line_rd(rd[1]),
        .line_cell_rdy(rdy[1]), .line_data(ldat[1]), .line_soc(lsoc[1]));

    int errs = 0, checks = 0;
    bit done = 0;
    int stored [2];
    bit inprog [2];
    logic [7:0] q0 [$];
    logic [7:0] q1 [$];

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] cb(int seed, int i);
        return 8'(seed * 37 + i * 11 + 5);
    endfunction

    // 16-bit bus word i of a cell; the pad low byte of word index 2 is 8'hEE
    function automatic logic [15:0] w16(int seed, int i);
        if (i < 2) return {cb(seed, 2*i), cb(seed, 2*i+1)};
        if (i == 2) return {cb(seed, 4), 8'hEE};
        return {cb(seed, 2*i-1), cb(seed, 2*i)};
    endfunction

    // Send nw words of cell 'seed' to copy u; bad parity on word badi
    task automatic send_words(int u, int seed, int nw, int badi);
        bit acc = 0;
        int wpc = (u == 0) ? 53 : 27;
        for (int i = 0; i < nw; i++) begin
            en[u] = 1'b1;
            soc[u] = (i == 0);
            if (u == 0) begin
                d8 = cb(seed, i);
                par[u] = ~(^d8) ^ (i == badi);
            end else begin
                d16 = w16(seed, i);
                par[u] = ~(^d16) ^ (i == badi);
            end
            @(posedge atm_clk);
            if (i == 0) begin
                acc = inprog[u] || (stored[u] < 4);
                if (acc) inprog[u] = 1;
            end
            if (acc && i == wpc - 1) begin
                inprog[u] = 0;
                stored[u]++;
                for (int k = 0; k < 53; k++) begin
                    if (u == 0) q0.push_back(cb(seed, k));
                    else q1.push_back(cb(seed, k));
                end
            end
            @(negedge atm_clk);
        end
        en[u] = 1'b0;
        soc[u] = 1'b0;
    endtask

    // Words with start-of-cell low and no cell in progress
    task automatic stray_words(int u, int n);
        for (int i = 0; i < n; i++) begin
            en[u] = 1'b1; soc[u] = 1'b0;
            d8 = 8'h5A; d16 = 16'h5A5A; par[u] = 1'b1;
            @(negedge atm_clk);
        end
        en[u] = 1'b0;
    endtask

    task automatic read_cell(int u, string tag);
        int t = 0;
        logic [7:0] e;
        @(negedge line_clk);
        while (!rdy[u] && t < 200) begin
            @(negedge line_clk);
            t++;
        end
        chk({tag, " cell ready"}, int'(rdy[u]), 1);
        for (int i = 0; i < 53; i++) begin
            e = (u == 0) ? q0[0] : q1[0];
            chk({tag, " byte"}, int'(ldat[u]), int'(e));
            chk({tag, " soc marker R3"}, int'(lsoc[u]), int'(i == 0));
            rd[u] = 1'b1;
            @(posedge line_clk);
            if (u == 0) void'(q0.pop_front()); else void'(q1.pop_front());
            if (i == 52) stored[u]--;
            @(negedge line_clk);
        end
        rd[u] = 1'b0;
    endtask

    task automatic idle_atm(int n);
        repeat (n) @(negedge atm_clk);
    endtask

    // Per-clock model comparison of the flow-control flag (R7)
    always @(negedge atm_clk) begin
        if (atm_rst_n && !done) begin
            for (int u = 0; u < 2; u++) begin
                if (stored[u] + int'(inprog[u]) >= 4) chk("R7 avail low when slots taken", int'(avail[u]), 0);
            end
        end
    end

    // Per-clock model comparison of line-side readiness (R10)
    always @(negedge line_clk) begin
        if (line_rst_n && !done) begin
            for (int u = 0; u < 2; u++) begin
                if (stored[u] == 0) chk("R10 rdy low when empty", int'(rdy[u]), 0);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge atm_clk);
        if (!done) begin
            errs++;
            $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        for (int u = 0; u < 2; u++) begin
            en[u] = 0; soc[u] = 0; par[u] = 0; rd[u] = 0;
            stored[u] = 0; inprog[u] = 0;
        end
        d8 = 0; d16 = 0;
        repeat (4) @(negedge line_clk);
        atm_rst_n = 1'b1;
        line_rst_n = 1'b1;
        idle_atm(6);

        // Reset state
        for (int u = 0; u < 2; u++) begin
            chk("reset avail R7", int'(avail[u]), 1);
            chk("reset rdy R10", int'(rdy[u]), 0);
            chk("reset par_err R4", int'(perr[u]), 0);
            chk("reset runt_err R5", int'(rerr[u]), 0);
        end

        // R3: read strobes while empty are ignored
        rd[0] = 1'b1;
        repeat (5) @(negedge line_clk);
        rd[0] = 1'b0;
        chk("R3 strobe while empty", int'(rdy[0]), 0);

        // R1 and R10: two 8-bit cells, read back in order
        send_words(0, 1, 53, -1);
        send_words(0, 2, 53, -1);
        read_cell(0, "R1 first");
        read_cell(0, "R10 second");

        // R2: 16-bit cell with a pad byte
        send_words(1, 3, 27, -1);
        read_cell(1, "R2 wide");

        // R6: stray words ignored
        stray_words(0, 3);
        send_words(0, 4, 53, -1);
        read_cell(0, "R6 after stray");
        repeat (6) @(negedge line_clk);
        chk("R6 no stray cell", int'(rdy[0]), 0);

        // R4: bad parity on one word, cell kept, flag sticky
        send_words(0, 5, 53, 10);
        chk("R4 par_err set", int'(perr[0]), 1);
        chk("R4 other copy clear", int'(perr[1]), 0);
        read_cell(0, "R4 bad parity cell");
        send_words(0, 6, 53, -1);
        chk("R4 par_err sticky", int'(perr[0]), 1);
        read_cell(0, "R4 later cell");

        // R5: runt on the 16-bit copy
        send_words(1, 7, 10, -1);
        send_words(1, 8, 27, -1);
        chk("R5 runt_err set", int'(rerr[1]), 1);
        read_cell(1, "R5 cell after runt");
        idle_atm(4);
        chk("R5 runt_err sticky", int'(rerr[1]), 1);

        // R7, R8, R9: fill, overflow, drain
        idle_atm(12);
        for (int c = 0; c < 3; c++) send_words(0, 10 + c, 53, -1);
        idle_atm(4);
        chk("R7 avail with one slot free", int'(avail[0]), 1);
        send_words(0, 13, 53, -1);
        chk("R7 avail low when full", int'(avail[0]), 0);
        send_words(0, 14, 53, -1);
        for (int c = 0; c < 4; c++) read_cell(0, "R8 stored cell");
        repeat (6) @(negedge line_clk);
        chk("R8 dropped cell absent", int'(rdy[0]), 0);
        chk("R8 no runt from drop", int'(rerr[0]), 0);
        idle_atm(10);
        chk("R9 avail back after drain", int'(avail[0]), 1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule